// File: doc/BRIEF.md
# Nibble-Bus Program Memory Adapter

This block connects a processor that shares a single 4-bit bus between addresses and data to an ordinary byte-wide program memory. That memory has its own parallel address input. The processor runs a fixed eight-phase cycle.

In the first three phases it sends a 12-bit program address, one nibble per phase. The adapter collects these nibbles and applies the whole address to the memory at once. In the next two phases the adapter returns the addressed byte as two nibbles on its bus driver. In the three execution phases that end the cycle it leaves the bus alone.

The adapter answers only for addresses inside a configurable window, so several such adapters can share one bus. A flag from the processor, raised during the execution phases, marks the following cycle as a second fetch. That cycle reads a data byte in the same way, and the adapter reports it as a data cycle.

Top module: `nibble_mem_adapter`

## Requirements
- R1: A high `sync_i` makes the current clock cycle phase 0. Without sync, phases advance by one per clock and wrap from 7 to 0, so a cycle that has no sync pulse behaves the same as one that has.
- R2: The bus nibble in phase 0 becomes address bits 3:0, the nibble in phase 1 becomes bits 7:4, and the nibble in phase 2 becomes bits 11:8.
- R3: `mem_addr_o` changes only at the clock edge that ends phase 2, where it takes the new 12-bit address. Through phases 0–2 of the following cycle it still shows the previous address.
- R4: In phase 3 `bus_out_o` carries bits 7:4 of `mem_data_i`. In phase 4 it carries bits 3:0.
- R5: `bus_oe_o` is low in phases 0, 1, 2, 5, 6 and 7. Whenever `bus_oe_o` is low, `bus_out_o` is 0.
- R6: `bus_oe_o` is high in phases 3 and 4 only when the committed address A satisfies WIN_BASE <= A < WIN_BASE+WIN_SIZE. For any other address it stays low.
- R7: If `second_fetch_i` is high in any of phases 5–7, `data_cycle_o` is high for all eight phases of the next cycle. The byte is returned in that cycle exactly as in R4.
- R8: `second_fetch_i` has no effect in phases 0–4, and none during a cycle whose `data_cycle_o` is already high. Second fetches never chain.
- R9: After reset, `bus_oe_o`, `bus_out_o`, `data_cycle_o` and `mem_addr_o` are all 0.
- R10: A sync pulse that arrives in the middle of a cycle restarts the phase count at 0. The next cycle captures and returns its address normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus phase clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Marks phase 0 of a cycle |
| second_fetch_i | input | 1 | Requests a data-fetch cycle next (sampled in phases 5–7) |
| bus_in_i | input | 4 | Nibble as seen on the shared bus |
| bus_out_o | output | 4 | Nibble driven onto the shared bus |
| bus_oe_o | output | 1 | Enable of the bus driver; when low the driver is high-impedance |
| mem_addr_o | output | 12 | Address to the program memory |
| mem_data_i | input | 8 | Byte read from the program memory |
| data_cycle_o | output | 1 | High during a second-fetch cycle |

## Verification
The bench runs addresses whose three nibbles all differ, so a swapped capture order or a swapped return order changes the observed values. It also probes the two edges of the window and the two addresses just outside them, which separates an off-by-one window from a correct one.

Cycles without sync, and a cycle cut short by an early sync, tell real phase tracking apart from a counter that only follows sync. The second-fetch flag is raised in the execution phases, in the early phases, and during a data cycle. This separates a correct sampling window and the no-chaining rule from a flag that is simply latched.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
    localparam int NIB_W      = 4;
    localparam int ADDR_NIBS  = 3;
    localparam int DATA_NIBS  = 2;
    localparam int EXEC_PH    = 3;
    localparam int CYCLE_LEN  = ADDR_NIBS + DATA_NIBS + EXEC_PH;
    localparam int ADDR_W     = NIB_W * ADDR_NIBS;
    localparam int DATA_W     = NIB_W * DATA_NIBS;
    localparam int PH_W       = $clog2(CYCLE_LEN);
    localparam int RET_FIRST  = ADDR_NIBS;
    localparam int RET_LAST   = ADDR_NIBS + DATA_NIBS - 1;
    localparam int EXEC_FIRST = RET_LAST + 1;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        addr_t addr;
        logic  hit;
    } fetch_t;

    function automatic logic addr_hit(addr_t a, int base, int size);
        return (int'(a) >= base) && (int'(a) < base + size);
    endfunction

    function automatic logic is_return(phase_t p);
        return (int'(p) >= RET_FIRST) && (int'(p) <= RET_LAST);
    endfunction

    function automatic logic is_exec(phase_t p);
        return int'(p) >= EXEC_FIRST;
    endfunction
endpackage

// File: rtl/nbm_phase.sv
module nbm_phase
    import nbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_i,
    output phase_t ph_o
);
    phase_t cnt_q;

    always_comb ph_o = sync_i ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (int'(ph_o) == CYCLE_LEN - 1)
            cnt_q <= '0;
        else
            cnt_q <= ph_o + phase_t'(1);
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (!sync_i && int'(ph_o) == CYCLE_LEN - 1) |=> (ph_o == '0));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (sync_i || ph_o == phase_t'(1)));
endmodule

// File: rtl/nbm_addr.sv
module nbm_addr
    import nbm_pkg::*;
#(
    parameter int WIN_BASE = 0,
    parameter int WIN_SIZE = 1 << nbm_pkg::ADDR_W
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_i,
    input  nib_t   bus_i,
    output fetch_t fetch_o
);
    nib_t   stage_q [ADDR_NIBS-1];
    addr_t  assembled;
    fetch_t fetch_q;
    logic   commit;

    always_comb commit = (int'(ph_i) == ADDR_NIBS - 1);

    for (genvar i = 0; i < ADDR_NIBS - 1; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[i] <= '0;
            else if (int'(ph_i) == i)
                stage_q[i] <= bus_i;
        end
        assign assembled[i*NIB_W +: NIB_W] = stage_q[i];
    end
    assign assembled[ADDR_W-1 -: NIB_W] = bus_i;

    always_ff @(posedge clk) begin
        if (rst)
            fetch_q <= '0;
        else if (commit) begin
            fetch_q.addr <= assembled;
            fetch_q.hit  <= addr_hit(assembled, WIN_BASE, WIN_SIZE);
        end
    end

    assign fetch_o = fetch_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(fetch_q));
endmodule

// File: rtl/nbm_return.sv
module nbm_return
    import nbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_i,
    input  logic   hit_i,
    input  byte_t  data_i,
    input  logic   second_fetch_i,
    output nib_t   bus_o,
    output logic   oe_o,
    output logic   data_cycle_o
);
    logic   ret;
    phase_t k;
    int     idx;
    logic   pend_q, dc_q;
    logic   pend_nx;

    always_comb begin
        ret  = is_return(ph_i);
        oe_o = ret && hit_i;
        k    = ph_i - phase_t'(RET_FIRST);
        idx  = (DATA_NIBS - 1 - int'(k)) * NIB_W;
        if (oe_o)
            bus_o = data_i[idx +: NIB_W];
        else
            bus_o = '0;
    end

    always_comb pend_nx = pend_q || (is_exec(ph_i) && second_fetch_i && !dc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            dc_q   <= 1'b0;
        end else if (int'(ph_i) == CYCLE_LEN - 1) begin
            dc_q   <= pend_nx;
            pend_q <= 1'b0;
        end else if (ph_i == '0) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_nx;
        end
    end

    assign data_cycle_o = dc_q;

    assert_oe_phase_R5: assert property (@(posedge clk) disable iff (rst)
        oe_o |-> (int'(ph_i) >= RET_FIRST && int'(ph_i) <= RET_LAST));

    assert_no_chain_R8: assert property (@(posedge clk) disable iff (rst)
        (dc_q && int'(ph_i) == CYCLE_LEN - 1) |=> !dc_q);

    assert_dc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(ph_i) != CYCLE_LEN - 1) |=> $stable(dc_q));
endmodule

// File: rtl/nibble_mem_adapter.sv
module nibble_mem_adapter
    import nbm_pkg::*;
#(
    parameter int WIN_BASE = 0,
    parameter int WIN_SIZE = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_i,
    input  logic        second_fetch_i,
    input  logic [3:0]  bus_in_i,
    output logic [3:0]  bus_out_o,
    output logic        bus_oe_o,
    output logic [11:0] mem_addr_o,
    input  logic [7:0]  mem_data_i,
    output logic        data_cycle_o
);
    phase_t ph;
    fetch_t fetch;

    nbm_phase i_phase (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .ph_o   (ph)
    );

    nbm_addr #(
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) i_addr (
        .clk     (clk),
        .rst     (rst),
        .ph_i    (ph),
        .bus_i   (bus_in_i),
        .fetch_o (fetch)
    );

    nbm_return i_ret (
        .clk            (clk),
        .rst            (rst),
        .ph_i           (ph),
        .hit_i          (fetch.hit),
        .data_i         (mem_data_i),
        .second_fetch_i (second_fetch_i),
        .bus_o          (bus_out_o),
        .oe_o           (bus_oe_o),
        .data_cycle_o   (data_cycle_o)
    );

    assign mem_addr_o = fetch.addr;

    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> (bus_out_o == 4'h0));
endmodule

// File: tb/test_nibble_mem_adapter.sv
module test_nibble_mem_adapter;
    localparam int BASE = 1024;
    localparam int SIZE = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_i = 1'b0;
    logic        second_fetch_i = 1'b0;
    logic [3:0]  bus_in_i = 4'h0;
    logic [3:0]  bus_out_o;
    logic        bus_oe_o;
    logic [11:0] mem_addr_o;
    logic [7:0]  mem_data_i;
    logic        data_cycle_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [11:0] prev_addr = 12'h000;

    always #10 clk = ~clk;

    function automatic logic [7:0] rom(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    assign mem_data_i = rom(mem_addr_o);

    nibble_mem_adapter #(.WIN_BASE(BASE), .WIN_SIZE(SIZE)) i_nibble_mem_adapter (
        .clk            (clk),
        .rst            (rst),
        .sync_i         (sync_i),
        .second_fetch_i (second_fetch_i),
        .bus_in_i       (bus_in_i),
        .bus_out_o      (bus_out_o),
        .bus_oe_o       (bus_oe_o),
        .mem_addr_o     (mem_addr_o),
        .mem_data_i     (mem_data_i),
        .data_cycle_o   (data_cycle_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // fmode: 0 = no flag, 1 = flag in phases 5-7, 2 = flag in phases 0-4
    task automatic run_cycle(input logic [11:0] a, input bit with_sync,
                             input int fmode, input bit exp_dc, input int len,
                             input string req);
        bit hit;
        logic [3:0] exp_nib;
        hit = (int'(a) >= BASE) && (int'(a) < BASE + SIZE);
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            sync_i = with_sync && (p == 0);
            bus_in_i = (p < 3) ? a[p*4 +: 4] : 4'hA;
            second_fetch_i = (fmode == 1 && p >= 5) || (fmode == 2 && p < 5);
            #5;
            if (p == 3 || p == 4) begin
                exp_nib = !hit ? 4'h0 : (p == 3 ? rom(a)[7:4] : rom(a)[3:0]);
                check(bus_oe_o == hit, hit ? "R6" : "R6 out-of-window", "oe", bus_oe_o, hit);
                check(bus_out_o == exp_nib, "R4", "nibble", bus_out_o, exp_nib);
                if (p == 3)
                    check(mem_addr_o == a, "R2", "assembled address", mem_addr_o, a);
            end else begin
                check(bus_oe_o == 1'b0, "R5", "oe outside return", bus_oe_o, 0);
                check(bus_out_o == 4'h0, "R5", "idle nibble", bus_out_o, 0);
                check(mem_addr_o == (p < 3 ? prev_addr : a), "R3", "address hold",
                      mem_addr_o, (p < 3 ? prev_addr : a));
            end
            check(data_cycle_o == exp_dc, req, "data_cycle", data_cycle_o, exp_dc);
        end
        if (len >= 3) prev_addr = a;
        sync_i = 1'b0;
        second_fetch_i = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk); @(negedge clk);
        #5;
        check(bus_oe_o == 1'b0, "R9", "oe in reset", bus_oe_o, 0);
        check(bus_out_o == 4'h0, "R9", "bus in reset", bus_out_o, 0);
        check(data_cycle_o == 1'b0, "R9", "data_cycle in reset", data_cycle_o, 0);
        check(mem_addr_o == 12'h000, "R9", "addr in reset", mem_addr_o, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_basic();
        run_cycle(12'h7A5, 1, 0, 0, 8, "R2");
        run_cycle(12'h400, 1, 0, 0, 8, "R6");
    endtask

    task automatic test_wrap();
        run_cycle(12'hBFF, 0, 0, 0, 8, "R1");
        run_cycle(12'h6C9, 0, 0, 0, 8, "R1");
    endtask

    task automatic test_window();
        run_cycle(12'hC00, 1, 0, 0, 8, "R6");
        run_cycle(12'h3FF, 1, 0, 0, 8, "R6");
    endtask

    task automatic test_second_fetch();
        run_cycle(12'h5D3, 1, 1, 0, 8, "R7");
        run_cycle(12'h456, 1, 1, 1, 8, "R7");
        run_cycle(12'h800, 1, 0, 0, 8, "R8 no chain");
        run_cycle(12'h921, 1, 2, 0, 8, "R8");
        run_cycle(12'h912, 1, 0, 0, 8, "R8 early flag");
    endtask

    task automatic test_cut();
        run_cycle(12'hA0F, 1, 0, 0, 5, "R10");
        run_cycle(12'h5C3, 1, 0, 0, 8, "R10");
    endtask

    initial begin
        test_reset();
        test_basic();
        test_wrap();
        test_window();
        test_second_fetch();
        test_cut();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule